// File: doc/BRIEF.md
# Flash Region Guard with Boot-Block Lockout

This block sits beside the command decoder of a word-addressed flash array. Each cycle it takes a 19-bit word address and an operation request: program a word, erase one parameter block, or erase the large sector. It reports which region the address falls in and which erase unit holds it. It then grants or denies the request. A synthesis parameter chooses where the protected boot block sits. In the bottom layout it sits at the low end of the address space. In the top layout the whole map is mirrored, so the boot block sits at the high end and the parameter blocks lie just below it.

A one-cycle enable pulse from the command decoder sets a sticky lockout flag. From then on, the block refuses any operation that would change the boot block. Only power-on reset clears the flag. The separate device reset input halts the current result but leaves the flag in place. An erase of the large sector is still granted while locked. In that case it carries a mask flag, so the erase engine clears only the main-array part and leaves the boot block alone. All outputs are registered and appear one clock after the request.

Top module: `flash_region_guard`

## Requirements
- R1: The region code uses these values: 2'b00 for the boot block, 2'b01 for parameter block 1, 2'b10 for parameter block 2, and 2'b11 for the main array. Each block is 8K words (0x2000). In the bottom layout (TOP_BOOT=0), the boot block starts at 0x00000, parameter block 1 at 0x02000, parameter block 2 at 0x04000, and the main array covers 0x06000 to 0x7FFFF.
- R2: The erase unit code uses these values: 2'd0 for parameter block 1, 2'd1 for parameter block 2, and 2'd2 for the sector made of the boot block plus the main array.
- R3: The op code uses these values: 0 none, 1 program, 2 parameter erase, 3 sector erase. While unlocked, a program request is granted for any address. Every result appears on the outputs at the clock edge after the request is sampled.
- R4: A parameter erase is granted only when the address lies in a parameter block. Otherwise it is denied. Lockout never changes this.
- R5: A sector erase is granted when the address lies in the boot block or the main array. It is denied when the address lies in a parameter block.
- R6: A pulse on lock_set_i sets the lockout flag, and the flag stays set. The flag already applies to a request sampled in the same cycle as the pulse.
- R7: While locked, a program request to the boot block is denied. A program request to any other region is still granted.
- R8: keep_boot_o is 1 exactly when a sector erase is granted while locked. In every other case it is 0.
- R9: grant_o and deny_o are never high together. Both are low when the op is none.
- R10: While dev_rst_ni is low, every output is cleared at the next edge. The lockout flag is kept, and a lock pulse during this time still takes effect.
- R11: rst_ni (power-on reset, asynchronous, active low) clears all outputs and the lockout flag.
- R12: In the top layout (TOP_BOOT=1), the map is mirrored. The boot block is 0x7E000 to 0x7FFFF, parameter block 1 is 0x7C000 to 0x7DFFF, parameter block 2 is 0x7A000 to 0x7BFFF, and the main array is 0x00000 to 0x79FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| dev_rst_ni | input | 1 | Device reset, synchronous, active low; keeps lockout |
| addr_i | input | 19 | Word address of the request |
| op_i | input | 2 | Operation request (R3 encoding) |
| lock_set_i | input | 1 | One-cycle lockout enable pulse |
| region_o | output | 2 | Region code of the address |
| unit_o | output | 2 | Erase unit holding the address |
| grant_o | output | 1 | Request allowed |
| deny_o | output | 1 | Request refused |
| keep_boot_o | output | 1 | Sector erase must spare the boot block |

## Verification
The hardest situations to reach are the locked ones, because the flag cannot be cleared except by power-on reset. The stimulus therefore runs its unlocked random traffic first and only then pulses the lock. One pulse is sent in the same cycle as a boot-block program request, and another is sent during a device reset. After that, a second round of random traffic runs in the locked state. Addresses are weighted toward the first and last words of every block in both layouts, so that each region boundary is crossed.

// File: rtl/flash_map_pkg.sv
package flash_map_pkg;
  typedef enum logic [1:0] {REG_BOOT = 2'b00, REG_PAR1 = 2'b01, REG_PAR2 = 2'b10, REG_MAIN = 2'b11} region_e;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_PROG = 2'd1, OP_PERASE = 2'd2, OP_SERASE = 2'd3} op_e;
  typedef enum logic [1:0] {UNIT_PAR1 = 2'd0, UNIT_PAR2 = 2'd1, UNIT_SECTOR = 2'd2, UNIT_RSVD = 2'd3} unit_e;
  typedef struct packed {
    logic grant;
    logic deny;
    logic keep_boot;
  } verdict_t;
endpackage

// File: rtl/region_decode.sv
module region_decode
  import flash_map_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLOCK_W  = 13,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output unit_e             unit_o
);
  localparam int IDX_W = ADDR_W - BLOCK_W;

  logic [IDX_W-1:0] idx;

  // mirrored layout: count blocks down from the top of the space
  generate
    if (TOP_BOOT) begin : g_top
      assign idx = ~addr_i[ADDR_W-1:BLOCK_W];
    end else begin : g_bottom
      assign idx = addr_i[ADDR_W-1:BLOCK_W];
    end
  endgenerate

  always_comb begin
    unique case (idx)
      IDX_W'(0): region_o = REG_BOOT;
      IDX_W'(1): region_o = REG_PAR1;
      IDX_W'(2): region_o = REG_PAR2;
      default:   region_o = REG_MAIN;
    endcase
  end

  always_comb begin
    unique case (region_o)
      REG_PAR1: unit_o = UNIT_PAR1;
      REG_PAR2: unit_o = UNIT_PAR2;
      default:  unit_o = UNIT_SECTOR;
    endcase
  end
endmodule

// File: rtl/lock_keeper.sv
module lock_keeper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic lock_eff_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lock_q <= 1'b0;
    else if (set_i) lock_q <= 1'b1;
  end

  // pulse takes effect for the request sampled alongside it
  assign lock_eff_o = lock_q | set_i;

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lock_q);
endmodule

// File: rtl/access_arbiter.sv
module access_arbiter
  import flash_map_pkg::*;
(
  input  op_e      op_i,
  input  region_e  region_i,
  input  logic     locked_i,
  output verdict_t verdict_o
);
  logic in_param;
  logic allow;

  assign in_param = (region_i == REG_PAR1) || (region_i == REG_PAR2);

  always_comb begin
    allow = 1'b0;
    unique case (op_i)
      OP_PROG:   allow = !(locked_i && region_i == REG_BOOT);
      OP_PERASE: allow = in_param;
      OP_SERASE: allow = !in_param;
      default:   allow = 1'b0;
    endcase
  end

  always_comb begin
    verdict_o.grant     = (op_i != OP_NONE) && allow;
    verdict_o.deny      = (op_i != OP_NONE) && !allow;
    verdict_o.keep_boot = (op_i == OP_SERASE) && allow && locked_i;
  end
endmodule

// File: rtl/flash_region_guard.sv
module flash_region_guard
  import flash_map_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLOCK_W  = 13,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        op_i,
  input  logic              lock_set_i,
  output logic [1:0]        region_o,
  output logic [1:0]        unit_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              keep_boot_o
);
  region_e  region_d;
  unit_e    unit_d;
  verdict_t verdict_d;
  logic     locked;
  op_e      op;

  assign op = op_e'(op_i);

  region_decode #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .TOP_BOOT(TOP_BOOT)) u_decode (
    .addr_i  (addr_i),
    .region_o(region_d),
    .unit_o  (unit_d)
  );

  lock_keeper u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (lock_set_i),
    .lock_eff_o(locked)
  );

  access_arbiter u_arb (
    .op_i     (op),
    .region_i (region_d),
    .locked_i (locked),
    .verdict_o(verdict_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      region_o    <= '0;
      unit_o      <= '0;
      grant_o     <= 1'b0;
      deny_o      <= 1'b0;
      keep_boot_o <= 1'b0;
    end else if (!dev_rst_ni) begin
      region_o    <= '0;
      unit_o      <= '0;
      grant_o     <= 1'b0;
      deny_o      <= 1'b0;
      keep_boot_o <= 1'b0;
    end else begin
      region_o    <= region_d;
      unit_o      <= unit_d;
      grant_o     <= verdict_d.grant;
      deny_o      <= verdict_d.deny;
      keep_boot_o <= verdict_d.keep_boot;
    end
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_NONE) |=> (!grant_o && !deny_o));
  p_boot_prog_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_ni && op == OP_PROG && locked && region_d == REG_BOOT) |=> deny_o);
  p_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_boot_o |-> grant_o);
  p_halt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_rst_ni |=> (!grant_o && !deny_o && !keep_boot_o));
  p_unit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_ni |=> (unit_o == 2'd2) == (region_o == 2'b00 || region_o == 2'b11));
endmodule

// File: tb/flash_region_guard_bench.sv
module flash_region_guard_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_rst_n = 1'b1;
  logic [18:0] addr = '0;
  logic [1:0]  op = 2'd0;
  logic        lock_set = 1'b0;

  logic [1:0] reg_b, unit_b, reg_t, unit_t;
  logic       gr_b, dn_b, kb_b, gr_t, dn_t, kb_t;

  int checks = 0;
  int errors = 0;
  bit lock_m = 1'b0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  flash_region_guard #(.TOP_BOOT(1'b0)) u_flash_region_guard (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_ni(dev_rst_n), .addr_i(addr), .op_i(op),
    .lock_set_i(lock_set), .region_o(reg_b), .unit_o(unit_b), .grant_o(gr_b),
    .deny_o(dn_b), .keep_boot_o(kb_b));

  flash_region_guard #(.TOP_BOOT(1'b1)) u_flash_region_guard_top (
    .clk_i(clk), .rst_ni(rst_n), .dev_rst_ni(dev_rst_n), .addr_i(addr), .op_i(op),
    .lock_set_i(lock_set), .region_o(reg_t), .unit_o(unit_t), .grant_o(gr_t),
    .deny_o(dn_t), .keep_boot_o(kb_t));

  function automatic logic [1:0] ref_region(logic [18:0] a, bit top);
    int unsigned v;
    v = top ? (32'h7FFFF - a) : a;
    if (v < 32'h2000) return 2'b00;
    if (v < 32'h4000) return 2'b01;
    if (v < 32'h6000) return 2'b10;
    return 2'b11;
  endfunction

  function automatic logic [1:0] ref_unit(logic [1:0] r);
    if (r == 2'b01) return 2'd0;
    if (r == 2'b10) return 2'd1;
    return 2'd2;
  endfunction

  // {region, unit, grant, deny, keep}
  function automatic logic [6:0] ref_out(logic [18:0] a, logic [1:0] o, bit lk, bit dv, bit top);
    logic [1:0] r;
    bit ok, par;
    if (!dv) return '0;
    r = ref_region(a, top);
    par = (r == 2'b01) || (r == 2'b10);
    case (o)
      2'd1:    ok = !(lk && r == 2'b00);
      2'd2:    ok = par;
      2'd3:    ok = !par;
      default: ok = 1'b0;
    endcase
    return {r, ref_unit(r), (o != 0) && ok, (o != 0) && !ok, (o == 2'd3) && ok && lk};
  endfunction

  function automatic string tag_for(logic [1:0] o, bit lk);
    case (o)
      2'd0: return "R9";
      2'd1: return lk ? "R7" : "R3";
      2'd2: return "R4";
      default: return lk ? "R8" : "R5";
    endcase
  endfunction

  task automatic cmp(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h op=%0d act=%b exp=%b", tag, addr, op, act, exp);
    end
  endtask

  task automatic step(logic [18:0] a, logic [1:0] o, bit set, bit dv, string tag);
    logic [6:0] eb, et;
    bit lk;
    @(negedge clk);
    addr = a; op = o; lock_set = set; dev_rst_n = dv;
    lk = lock_m | set;
    eb = ref_out(a, o, lk, dv, 1'b0);
    et = ref_out(a, o, lk, dv, 1'b1);
    @(posedge clk);
    lock_m = lk;
    #1;
    cmp((tag == "") ? tag_for(o, lk) : tag, {reg_b, unit_b, gr_b, dn_b, kb_b}, eb);
    cmp((tag == "") ? "R12" : tag, {reg_t, unit_t, gr_t, dn_t, kb_t}, et);
    lock_set = 1'b0;
  endtask

  function automatic logic [18:0] pick_addr();
    int unsigned idx, off;
    if ($urandom_range(1, 0) == 0) return 19'($urandom);
    idx = $urandom_range(5, 0);
    idx = (idx < 3) ? idx : (idx + 58);
    case ($urandom_range(2, 0))
      0: off = 0;
      1: off = 13'h1FFF;
      default: off = $urandom_range(13'h1FFF, 0);
    endcase
    return 19'((idx << 13) | off);
  endfunction

  task automatic random_phase(int n);
    for (int i = 0; i < n; i++)
      step(pick_addr(), 2'($urandom_range(3, 0)), 1'b0, 1'b1, "");
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [18:0] corners [12];
    void'($urandom(32'd1234));
    corners = '{19'h00000, 19'h01FFF, 19'h02000, 19'h03FFF, 19'h04000, 19'h05FFF,
                19'h06000, 19'h79FFF, 19'h7A000, 19'h7C000, 19'h7E000, 19'h7FFFF};
    #(CLK_NS * 3 + 2);
    cmp("R11", {reg_b, unit_b, gr_b, dn_b, kb_b}, '0);
    rst_n = 1'b1;

    // R1 R2 R12 boundaries, every op, unlocked
    foreach (corners[k])
      for (int o = 0; o < 4; o++)
        step(corners[k], 2'(o), 1'b0, 1'b1, "R1");
    random_phase(400);

    // R6: pulse alongside a boot program -> denied in the same cycle
    step(19'h00010, 2'd1, 1'b1, 1'b1, "R6");
    step(19'h7FFF0, 2'd1, 1'b0, 1'b1, "R6");
    // R8 masked sector erase, R7 non-boot program
    step(19'h00000, 2'd3, 1'b0, 1'b1, "R8");
    step(19'h40000, 2'd1, 1'b0, 1'b1, "R7");
    step(19'h02000, 2'd2, 1'b0, 1'b1, "R4");
    // R10: device reset clears outputs, keeps lock
    step(19'h00000, 2'd1, 1'b0, 1'b0, "R10");
    step(19'h00000, 2'd1, 1'b0, 1'b1, "R10");
    random_phase(400);

    // R11: power-on reset clears the lock
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp("R11", {reg_b, unit_b, gr_b, dn_b, kb_b}, '0);
    lock_m = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(19'h00000, 2'd1, 1'b0, 1'b1, "R11");
    step(19'h00000, 2'd3, 1'b0, 1'b1, "R11");

    // R10: pulse during device reset still locks
    step(19'h00000, 2'd1, 1'b1, 1'b0, "R10");
    step(19'h00000, 2'd1, 1'b0, 1'b1, "R10");
    random_phase(200);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule